// File: doc/BRIEF.md
# I2C Configuration Register Bank with Timed Commit

This block is an I2C target that keeps five byte-wide configuration registers and imitates the way a nonvolatile store commits them. A bus controller first addresses the block. It then writes a register pointer and one or more data bytes, or it reads bytes back starting at the pointer. Values that are written land in shadow registers at once, and reads return those shadow values. The parallel outputs that configure the rest of the chip change only when a commit completes.

A STOP that ends a transaction which stored at least one byte starts a commit window lasting a fixed number of system clocks. While that window runs, the block ignores every START and drives no ACK. When the window ends, the shadow values are copied to the outputs. The same quiet window also runs once right after reset, which models the power-up load. The outputs are:

- a full 8-bit reference code;
- a full 8-bit slope code;
- a gain multiplier decoded from the two low bits of register 2.

SCL and SDA are sampled on the faster system clock through two-flop synchronisers. The block pulls SDA low through an open-drain enable.

Top module: `cfg_i2c_regbank`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. No bus activity is acted on until a START is seen, and an address byte whose upper seven bits differ from DEV_ADDR (default 7'h50) gets no ACK.
- R2: A matching address byte is ACKed. Its bit 0 selects the direction: 0 means write and 1 means read. Every byte travels MSB first.
- R3: In a write, the first byte after the address is the register pointer and is always ACKed. Each later byte is stored at the pointer and ACKed, and the pointer then advances by one. The pointer also advances after every byte that is read.
- R4: A data byte written while the pointer is above 4 is NACKed and stored nowhere. A read while the pointer is above 4 returns 8'hFF.
- R5: A read returns the most recently written value of each register, including values not yet committed. SDA is driven only for read data bits and for ACKs, and a controller NACK ends the read.
- R6: ref_code equals committed register 0, and slope_code equals committed register 1.
- R7: gain_mult decodes committed register 2 bits 1:0 as 00→1, 01→2, 10→2, 11→4. Bits 7:2 of register 2 are plain storage that can be read back.
- R8: A STOP that ends a transaction which stored at least one byte starts a commit of COMMIT_CYCLES system clocks. The outputs change only when that commit ends.
- R9: During a commit and during the COMMIT_CYCLES clocks after reset, START is ignored and no ACK is driven.
- R10: A STOP after a read, or after a write that stored no byte, starts no commit, so the next START is accepted at once.
- R11: After reset, sda_oe is 0, ref_code and slope_code are 0, and gain_mult is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ref_code | output | 8 | Committed reference code (register 0) |
| slope_code | output | 8 | Committed slope code (register 1) |
| gain_mult | output | 3 | Committed gain multiplier: 1, 2 or 4 |

## Verification
The bound checker watches four properties on every cycle:

- the commit counter counts down by exactly one;
- the outputs hold still except on the cycle a commit ends;
- SDA stays released during any quiet window, and a START in that window leaves the block idle;
- a data byte written to a pointer above 4 gets no ACK.

Other behaviours can only be shown by the bench's transactions, because they span whole transfers:

- address matching;
- pointer auto-increment across writes and reads;
- read-back of uncommitted shadow values and 8'hFF beyond register 4;
- every gain code, including the two codes that both give x2;
- the rule that only a STOP after a stored byte launches a commit.

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int COMMIT_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] ref_code,
  output logic [7:0] slope_code,
  output logic [2:0] gain_mult
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam int NREG = 5;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD} st_t;

  logic [2:0]    scl_s, sda_s;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic          start_c, stop_c, rise, fall, busy, in_range;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, ptr, rd_byte;
  logic          mnack, dirty;
  logic [CW-1:0] busy_cnt;
  logic [7:0]    regs [NREG];
  logic [7:0]    ref_q, slope_q;
  logic [1:0]    gain_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  assign scl_q    = scl_s[1];
  assign scl_d    = scl_s[2];
  assign sda_q    = sda_s[1];
  assign sda_d    = sda_s[2];
  assign start_c  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_c   = scl_q & scl_d & ~sda_d & sda_q;
  assign rise     = scl_q & ~scl_d;
  assign fall     = ~scl_q & scl_d;
  assign busy     = busy_cnt != '0;
  assign in_range = ptr < 8'(NREG);

  always_comb begin
    rd_byte = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (ptr == 8'(i)) rd_byte = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      mnack    <= 1'b0;
      dirty    <= 1'b0;
      sda_oe   <= 1'b0;
      busy_cnt <= CW'(COMMIT_CYCLES);
      ref_q    <= '0;
      slope_q  <= '0;
      gain_q   <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CW'(1)) begin
          ref_q   <= regs[0];
          slope_q <= regs[1];
          gain_q  <= regs[2][1:0];
        end
      end
      if (start_c && !busy) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        mnack  <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (dirty && !busy) begin
          busy_cnt <= CW'(COMMIT_CYCLES);
          dirty    <= 1'b0;
        end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_q};
          if (cnt == 4'd8 && st == S_RD) mnack <= sda_q;
          cnt <= cnt + 1'b1;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= sh[0] ? S_RD : S_PTR;
                end else st <= S_IDLE;
              S_PTR: begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                st     <= S_WR;
              end
              S_WR: begin
                if (in_range) begin
                  for (int i = 0; i < NREG; i++)
                    if (ptr == 8'(i)) regs[i] <= sh;
                  dirty  <= 1'b1;
                  sda_oe <= 1'b1;
                end
                ptr <= ptr + 1'b1;
              end
              S_RD: begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
              end
              default: st <= S_IDLE;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (st == S_RD && !mnack) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              sda_oe <= 1'b0;
              if (st == S_RD) st <= S_IDLE;
            end
          end else if (st == S_RD && cnt < 4'd8)
            sda_oe <= ~tx[3'd7 - cnt[2:0]];
        end
      end
    end

  assign ref_code   = ref_q;
  assign slope_code = slope_q;
  assign gain_mult  = (gain_q == 2'b11) ? 3'd4 : (gain_q == 2'b00) ? 3'd1 : 3'd2;
endmodule

// File: rtl/cfg_i2c_regbank_chk.sv
module cfg_i2c_regbank_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] busy_cnt,
  input logic [2:0]    st,
  input logic          start_c,
  input logic          fall,
  input logic [3:0]    cnt,
  input logic [7:0]    ptr,
  input logic          sda_oe,
  input logic [7:0]    ref_code,
  input logic [7:0]    slope_code,
  input logic [2:0]    gain_mult
);
  AST_QUIET_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |-> !sda_oe); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0 && start_c) |=> (st == 3'd0)); // R9
  AST_COMMIT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R8
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != CW'(1)) |=> ($stable(ref_code) && $stable(slope_code) && $stable(gain_mult))); // R8
  AST_NACK_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && fall && cnt == 4'd8 && ptr > 8'd4) |=> !sda_oe); // R4
endmodule

bind cfg_i2c_regbank cfg_i2c_regbank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_cnt(busy_cnt), .st(st), .start_c(start_c),
  .fall(fall), .cnt(cnt), .ptr(ptr), .sda_oe(sda_oe), .ref_code(ref_code),
  .slope_code(slope_code), .gain_mult(gain_mult)
);

// File: tb/cfg_i2c_regbank_bench.sv
module cfg_i2c_regbank_bench;
  localparam int CC = 200;
  localparam int Q  = 8;
  localparam logic [7:0] AW = 8'hA0;
  localparam logic [7:0] AR = 8'hA1;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] ref_code, slope_code;
  logic [2:0] gain_mult;
  int checks = 0, fails = 0;
  logic [7:0] mreg [5];
  logic [7:0] creg [3];

  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_regbank #(.DEV_ADDR(7'h50), .COMMIT_CYCLES(CC)) u_cfg_i2c_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ref_code(ref_code), .slope_code(slope_code), .gain_mult(gain_mult));

  always #10 clk = ~clk;

  function automatic int exp_gain(input logic [1:0] c);
    return (c == 2'b11) ? 4 : (c == 2'b00) ? 1 : 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = (sda_bus == 1'b0); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_bus; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic commit_model();
    creg[0] = mreg[0]; creg[1] = mreg[1]; creg[2] = mreg[2];
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " R6 ref"}, ref_code, creg[0]);
    check({tag, " R6 slope"}, slope_code, creg[1]);
    check({tag, " R7 gain"}, gain_mult, exp_gain(creg[2][1:0]));
  endtask

  task automatic write_seq(input int p, input int n, input logic [7:0] d [4], input string tag);
    bit ack;
    i2c_start();
    wbyte(AW, ack); check({tag, " R2 addr ack"}, ack, 1);
    wbyte(8'(p), ack); check({tag, " R3 ptr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(d[k], ack);
      check({tag, " R3/R4 data ack"}, ack, (p + k < 5) ? 1 : 0);
      if (p + k < 5) mreg[p + k] = d[k];
    end
    i2c_stop();
  endtask

  task automatic read_seq(input int p, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    i2c_start();
    wbyte(AW, ack); check({tag, " R2 addr ack"}, ack, 1);
    wbyte(8'(p), ack);
    i2c_start();
    wbyte(AR, ack); check({tag, " R2 read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(b, k != n - 1);
      check({tag, " R5/R4 read data"}, b, (p + k < 5) ? mreg[p + k] : 8'hFF);
    end
    i2c_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d [4];
    int unsigned s;
    s = $urandom(32'd1234);
    for (int i = 0; i < 5; i++) mreg[i] = 8'h00;
    commit_model();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 sda released", sda_oe, 0);
    check_outputs("R11 reset");

    i2c_start(); wbyte(AW, ack); i2c_stop();
    check("R9 power-up start ignored", ack, 0);
    repeat (CC + 20) @(negedge clk);

    i2c_start(); wbyte(8'hA2, ack); i2c_stop();
    check("R1 foreign address no ack", ack, 0);

    d[0] = 8'h3C; d[1] = 8'h96; d[2] = 8'hFE; d[3] = 8'h11;
    write_seq(0, 4, d, "burst");
    check_outputs("R8 before commit");
    i2c_start(); wbyte(AW, ack); i2c_stop();
    check("R9 start during commit", ack, 0);
    repeat (CC + 20) @(negedge clk);
    commit_model();
    check_outputs("R8 after commit");

    d[0] = 8'h22; d[1] = 8'h77;
    write_seq(4, 2, d, "edge");
    repeat (CC + 20) @(negedge clk);
    read_seq(0, 6, "readback");

    i2c_start(); wbyte(AW, ack); i2c_stop();
    check("R10 no commit after read", ack, 1);
    i2c_start(); wbyte(AW, ack); wbyte(8'h01, ack); i2c_stop();
    i2c_start(); wbyte(AW, ack); i2c_stop();
    check("R10 no commit after ptr-only write", ack, 1);

    for (int c = 0; c < 4; c++) begin
      d[0] = {6'b101010, 2'(c)};
      write_seq(2, 1, d, "gain");
      repeat (CC + 20) @(negedge clk);
      commit_model();
      check("R7 gain code", gain_mult, exp_gain(2'(c)));
    end
    read_seq(2, 1, "R7 upper bits");

    for (int t = 0; t < 20; t++) begin
      int p, n;
      bit any;
      p = $urandom_range(0, 5);
      n = $urandom_range(1, 3);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      any = (p < 5);
      write_seq(p, n, d, "rand");
      if (any) begin
        i2c_start(); wbyte(AW, ack); i2c_stop();
        check("R9 rand busy", ack, 0);
        repeat (CC + 20) @(negedge clk);
        commit_model();
      end else begin
        i2c_start(); wbyte(AW, ack); i2c_stop();
        check("R10 rand idle", ack, 1);
      end
      check_outputs("rand");
      read_seq($urandom_range(0, 5), 2, "rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule